// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 interrupt sources into one bank of registers and raises a single interrupt line. Hardware event pulses set bits in a cause register. Software reads the cause directly, or through a view with the masked sources removed. It acknowledges each source in one of two ways, chosen bit by bit. The first way is to write a one to the bit. The second way is to read it, because the read clears it. Bit position n belongs to the same source in every register of the bank.

Software reaches the bank over a plain register bus: a byte address, a write strobe with data, and a read strobe with combinational read data. The cause register has a set alias, so software can raise a source itself. The mask has set and clear aliases, so one field can be changed without a read-modify-write. The mask can also be written whole.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset the mode, cause and mask registers all read zero and `irq_o` is low.
- R2: A high `hw_event` bit sets the matching cause bit at the next clock edge. If any clear hits that bit in the same cycle, the event wins and the bit stays set.
- R3: The mode register (byte offset 0x00) is read/write. A 0 in bit n makes cause bit n write-one-to-clear, and a 1 makes it clear-on-read.
- R4: Writing the cause register (0x04) clears every bit that is written as 1 and is in write-one-to-clear mode. Bits in clear-on-read mode and bits written as 0 keep their value.
- R5: A read of the cause register returns the cause. At the edge that ends the read cycle it clears the returned bits that are in clear-on-read mode. Reads leave write-one-to-clear bits unchanged.
- R6: The masked cause view (0x08) reads as cause AND NOT mask. Writes to it clear bits under the rule of R4. A read of it clears only the bits it returned that are in clear-on-read mode.
- R7: Writing a 1 to a bit of the cause-set register (0x0C) sets that cause bit.
- R8: The mask register (0x10) is read/write, and a write replaces the whole mask.
- R9: Writing a 1 to a bit of mask-set (0x14) sets that mask bit. Writing a 1 to a bit of mask-clear (0x18) clears that mask bit. Bits written as 0 are unchanged.
- R10: Reads of cause-set, mask-set, mask-clear and the unused offset 0x1C return zero.
- R11: `irq_o` is a register. After each clock edge it holds the OR of the masked cause bits as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (5) | Byte address; bits [4:2] select the register, bits [1:0] are ignored |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | DATA_W (32) | Write data |
| reg_rd_en | input | 1 | Read strobe; clear-on-read takes effect at the edge ending this cycle |
| reg_rd_data | output | DATA_W (32) | Combinational read data for reg_addr |
| hw_event | input | DATA_W (32) | Per-source event inputs, one bit per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that a write and a read never share a cycle. The read data and the clear-on-read decision both follow the single address, and a write in the same cycle would change the rules an assertion checks. They also assume that addresses above the decoded window are not used. The bench's random traffic therefore picks one operation per cycle: a write, a read, or neither. Every address it draws falls in the eight decoded words. Events are drawn sparsely and do overlap writes and reads, which exercises the rule that an event beats a clear.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
   typedef enum logic [2:0] {
      REG_MODE   = 3'd0,
      REG_CAUSE  = 3'd1,
      REG_MCAUSE = 3'd2,
      REG_CSET   = 3'd3,
      REG_MASK   = 3'd4,
      REG_MSET   = 3'd5,
      REG_MCLR   = 3'd6,
      REG_SPARE  = 3'd7
   } irq_reg_e;

   localparam int unsigned WORD_LSB = 2;
   localparam int unsigned SEL_BITS = 3;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import irq_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output irq_reg_e          sel
);
   localparam int unsigned TOP_BIT = WORD_LSB + SEL_BITS;

   if (ADDR_W < TOP_BIT) begin : g_addr_too_small
      $error("irq_addr_dec: ADDR_W must be at least %0d", TOP_BIT);
   end

   assign sel = irq_reg_e'(addr[TOP_BIT-1:WORD_LSB]);

   if (ADDR_W > TOP_BIT) begin : g_upper_decode
      assign hit = (addr[ADDR_W-1:TOP_BIT] == '0);
   end else begin : g_exact_window
      assign hit = 1'b1;
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              set_req,
   input  logic              clr_req,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_q
);
   logic [DATA_W-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (load)    mask_d = wdata;
      if (set_req) mask_d = mask_q | wdata;
      if (clr_req) mask_d = mask_q & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end
endmodule

// File: rtl/irq_cause_bits.sv
module irq_cause_bits #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic              ack_we,
   input  logic              set_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] read_clr,
   input  logic [DATA_W-1:0] event_in,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] cause_q
);
   logic [DATA_W-1:0] cause_d;
   logic [DATA_W-1:0] wr_clr;
   logic [DATA_W-1:0] wr_set;

   assign wr_clr = ack_we ? (wdata & ~mode_q) : '0;
   assign wr_set = set_we ? wdata : '0;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      always_comb begin
         if (event_in[b] || wr_set[b])
            cause_d[b] = 1'b1;
         else if (wr_clr[b] || read_clr[b])
            cause_d[b] = 1'b0;
         else
            cause_d[b] = cause_q[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         cause_q <= '0;
      end else begin
         if (mode_we) mode_q <= wdata;
         cause_q <= cause_d;
      end
   end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
   import irq_bank_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wr_data,
   input  logic              reg_rd_en,
   output logic [DATA_W-1:0] reg_rd_data,
   input  logic [DATA_W-1:0] hw_event,
   output logic              irq_o
);
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("irq_cause_bank: DATA_W must lie in 1..32");
   end

   logic              hit;
   irq_reg_e          sel;
   logic              wr_hit;
   logic              rd_hit;
   logic [DATA_W-1:0] mode_q;
   logic [DATA_W-1:0] cause_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] masked;
   logic [DATA_W-1:0] read_clr;

   irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (reg_addr),
      .hit  (hit),
      .sel  (sel)
   );

   assign wr_hit = reg_wr_en && hit;
   assign rd_hit = reg_rd_en && hit;
   assign masked = cause_q & ~mask_q;

   always_comb begin
      read_clr = '0;
      if (rd_hit && sel == REG_CAUSE)  read_clr = cause_q & mode_q;
      if (rd_hit && sel == REG_MCAUSE) read_clr = masked & mode_q;
   end

   irq_cause_bits #(.DATA_W(DATA_W)) u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_we  (wr_hit && sel == REG_MODE),
      .ack_we   (wr_hit && (sel == REG_CAUSE || sel == REG_MCAUSE)),
      .set_we   (wr_hit && sel == REG_CSET),
      .wdata    (reg_wr_data),
      .read_clr (read_clr),
      .event_in (hw_event),
      .mode_q   (mode_q),
      .cause_q  (cause_q)
   );

   irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_hit && sel == REG_MASK),
      .set_req (wr_hit && sel == REG_MSET),
      .clr_req (wr_hit && sel == REG_MCLR),
      .wdata   (reg_wr_data),
      .mask_q  (mask_q)
   );

   always_comb begin
      reg_rd_data = '0;
      if (hit) begin
         case (sel)
            REG_MODE:   reg_rd_data = mode_q;
            REG_CAUSE:  reg_rd_data = cause_q;
            REG_MCAUSE: reg_rd_data = masked;
            REG_MASK:   reg_rd_data = mask_q;
            default:    reg_rd_data = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |masked;
   end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] evt,
   input logic              irq,
   input logic [DATA_W-1:0] mode,
   input logic [DATA_W-1:0] cause,
   input logic [DATA_W-1:0] mask
);
   logic [2:0] idx;
   logic       in_win;
   assign idx    = addr[4:2];
   assign in_win = ((addr >> 5) == '0);

   assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((cause & $past(evt)) == $past(evt)));

   assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && idx == 3'd1)
      |=> ((cause & $past(wr_data & ~mode & ~evt)) == '0));

   assert_masked_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && in_win && idx == 3'd2) |-> (rd_data == (cause & ~mask)));

   assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && idx == 3'd3) |=> ((cause & $past(wr_data)) == $past(wr_data)));

   assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && idx == 3'd5) |=> ((mask & $past(wr_data)) == $past(wr_data)));

   assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && idx == 3'd6) |=> ((mask & $past(wr_data)) == '0));

   assert_wo_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && in_win && (idx == 3'd3 || idx == 3'd5 || idx == 3'd6 || idx == 3'd7))
      |-> (rd_data == '0));

   assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past((cause & ~mask) != '0)));
endmodule

bind irq_cause_bank irq_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (reg_addr),
   .wr_en   (reg_wr_en),
   .wr_data (reg_wr_data),
   .rd_en   (reg_rd_en),
   .rd_data (reg_rd_data),
   .evt     (hw_event),
   .irq     (irq_o),
   .mode    (mode_q),
   .cause   (cause_q),
   .mask    (mask_q)
);

// File: tb/test_irq_cause_bank.sv
module test_irq_cause_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic        reg_rd_en = 1'b0;
   logic [31:0] reg_rd_data;
   logic [31:0] hw_event = '0;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_mode = '0, m_cause = '0, m_mask = '0;
   logic        m_irq = 1'b0;

   always #4 clk = ~clk;

   irq_cause_bank i_irq_cause_bank (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
      .hw_event(hw_event), .irq_o(irq_o)
   );

   function automatic logic [31:0] model_read(input logic [4:0] a);
      case (a[4:2])
         3'd0:    return m_mode;
         3'd1:    return m_cause;
         3'd2:    return m_cause & ~m_mask;
         3'd4:    return m_mask;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit wr, input bit rd,
                       input logic [4:0] a, input logic [31:0] d, input logic [31:0] e);
      logic [31:0] clr, set, nmask;
      @(negedge clk);
      reg_addr = a; reg_wr_en = wr; reg_rd_en = rd; reg_wr_data = d; hw_event = e;
      #1;
      if (rd) check(tag, reg_rd_data, model_read(a));
      check("R11", {31'b0, irq_o}, {31'b0, m_irq});
      @(posedge clk);
      clr = '0; set = e; nmask = m_mask;
      if (wr) begin
         case (a[4:2])
            3'd1, 3'd2: clr |= d & ~m_mode;
            3'd3: set |= d;
            3'd4: nmask = d;
            3'd5: nmask = m_mask | d;
            3'd6: nmask = m_mask & ~d;
            default: ;
         endcase
      end
      if (rd && a[4:2] == 3'd1) clr |= m_cause & m_mode;
      if (rd && a[4:2] == 3'd2) clr |= m_cause & ~m_mask & m_mode;
      m_irq = |(m_cause & ~m_mask);
      if (wr && a[4:2] == 3'd0) m_mode = d;
      m_cause = (m_cause & ~clr) | set;
      m_mask = nmask;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset values
      step("R1", 0, 1, 5'h00, 0, 0);
      step("R1", 0, 1, 5'h04, 0, 0);
      step("R1", 0, 1, 5'h10, 0, 0);
      check("R1", {31'b0, irq_o}, 32'h0);
      // R7: software set
      step("R7", 1, 0, 5'h0C, 32'h0000_00F0, 0);
      step("R7", 0, 1, 5'h04, 0, 0);
      // R4: write-one-to-clear
      step("R4", 1, 0, 5'h04, 32'h0000_0030, 0);
      step("R4", 0, 1, 5'h04, 0, 0);
      // R3: mode register, bit 7 clear-on-read
      step("R3", 1, 0, 5'h00, 32'h0000_0080, 0);
      step("R3", 0, 1, 5'h00, 0, 0);
      // R4: write to clear-on-read bit has no effect
      step("R4", 1, 0, 5'h04, 32'h0000_0080, 0);
      step("R4", 0, 1, 5'h05, 0, 0);
      // R5: read clears only clear-on-read bits
      step("R5", 0, 1, 5'h04, 0, 0);
      step("R5", 0, 1, 5'h04, 0, 0);
      // R2: event beats a simultaneous clear
      step("R2", 1, 0, 5'h04, 32'h0000_0040, 32'h0000_0040);
      step("R2", 0, 1, 5'h04, 0, 32'h0001_0000);
      step("R2", 0, 1, 5'h04, 0, 0);
      // R8: mask replace
      step("R8", 1, 0, 5'h10, 32'h0001_0040, 0);
      step("R8", 0, 1, 5'h10, 0, 0);
      // R6: masked view and its clear-on-read
      step("R6", 1, 0, 5'h0C, 32'h0000_0080, 0);
      step("R6", 0, 1, 5'h08, 0, 0);
      step("R6", 0, 1, 5'h04, 0, 0);
      step("R6", 1, 0, 5'h08, 32'h0001_0000, 0);
      step("R6", 0, 1, 5'h04, 0, 0);
      // R9: mask set and clear aliases
      step("R9", 1, 0, 5'h14, 32'h0000_0003, 0);
      step("R9", 1, 0, 5'h18, 32'h0000_0040, 0);
      step("R9", 0, 1, 5'h10, 0, 0);
      // R10: write-only and spare offsets read zero
      step("R10", 0, 1, 5'h0C, 0, 0);
      step("R10", 0, 1, 5'h14, 0, 0);
      step("R10", 0, 1, 5'h18, 0, 0);
      step("R10", 0, 1, 5'h1C, 0, 0);
      // R11: interrupt follows masked cause
      step("R11", 1, 0, 5'h10, 32'hFFFF_FFFF, 0);
      step("R11", 0, 0, 5'h00, 0, 0);
      step("R11", 1, 0, 5'h18, 32'h0000_0040, 0);
      step("R11", 0, 0, 5'h00, 0, 0);
      step("R11", 0, 0, 5'h00, 0, 0);
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         bit wr, rd;
         r  = $urandom;
         wr = r[0];
         rd = !r[0] && r[1];
         step("R6", wr, rd, {r[4:2], r[6:5]}, $urandom & $urandom,
              (r[9:7] == 3'd0) ? ($urandom & $urandom & $urandom) : 32'h0);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule